// File: doc/BRIEF.md
# Dual-Port Double-Rate Burst SRAM Command Pipeline

This block is a cycle-accurate behavioural model of the command and data timing of a synchronous SRAM with two independent data ports. Each access moves a burst of two data words. The block runs on a clock at twice the memory clock rate, so each of its cycles is one half of a memory clock. Even half-cycles belong to port A and model the rising memory edge. Odd half-cycles belong to port B and model the falling edge. Both ports share one address bus.

On its own half-cycle, a port's load strobe and read/write strobe are decoded and the address is captured. A write takes its two data words from the port's write-data bus at a fixed delay. A read returns its two words on the port's read-data bus at a longer fixed delay. Each read drives a valid strobe that runs one half-cycle ahead of the data, and an output enable that covers exactly the two data words. The words live in a small internal array indexed by the address and the word-in-burst bit.

Top module: `dp_burst_sram`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, a_rvalid, b_rvalid, a_oe and b_oe are 0, a_rdata and b_rdata are 0, and a_slot is 1.
- R2: a_slot is 1 before every even clk edge counted from reset release (edge 0) and 0 before every odd edge. Even edges sample port A's strobes and odd edges sample port B's, each with cmd_addr. The other port's strobes have no effect on that edge.
- R3: On a port's edge, ld_n=0 with rw_n=1 is a read, ld_n=0 with rw_n=0 is a write, and ld_n=1 is no operation regardless of rw_n. A no-operation changes no stored word and produces no output.
- R4: For a write sampled at edge t, word 0 is taken from that port's wdata at edge t+6 and word 1 at edge t+7. Write data at all other edges is ignored.
- R5: For a read sampled at edge t, rdata carries word 0 after edge t+10 and word 1 after edge t+11.
- R6: For a read sampled at edge t, rvalid is 1 after edges t+9 and t+10 only. It leads the data by one clk cycle at both the start and the end.
- R7: For a read sampled at edge t, oe is 1 after edges t+10 and t+11 and released at t+12. rdata is 0 whenever oe is 0.
- R8: Reads on the same port at consecutive own edges (every 2 clk cycles) give rvalid and oe with no gap.
- R9: A read returns the data of the most recent write to the same address, from either port, sampled on an earlier edge. This holds even when that write's data had not yet been taken when the read was sampled. Writes sampled later do not affect it.
- R10: Word 0 and word 1 of each address are separate locations. A location never written since reset reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; one cycle is half a memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_slot | output | 1 | 1 when the next clk edge samples port A |
| cmd_addr | input | ADDR_W | Shared address bus |
| a_ld_n | input | 1 | Port A load strobe, active low |
| a_rw_n | input | 1 | Port A read (1) / write (0) select |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| a_rvalid | output | 1 | Port A read-valid strobe |
| a_oe | output | 1 | Port A data bus output enable |
| b_ld_n | input | 1 | Port B load strobe, active low |
| b_rw_n | input | 1 | Port B read (1) / write (0) select |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |
| b_rvalid | output | 1 | Port B read-valid strobe |
| b_oe | output | 1 | Port B data bus output enable |

## Verification
Isolated writes followed by later reads fix the write-capture and read-return latencies. Reads of never-written addresses and of separate burst words show the array indexing. Back-to-back reads on one port and interleaved reads on both ports show whether valid and enable stay continuous, and whether the two ports' edges stay apart. Reads placed between a write and its data capture, and writes placed just after a read, separate true command ordering from plain array timing. No-operations with the write select low, and the idle port's strobes driven with hashed junk on every edge, show that those inputs are ignored. A long hashed mixed stretch then covers the combinations that the directed cases miss.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
    localparam int BURST_LEN = 2;
    localparam int N_PORT    = 2;
    localparam logic PORT_A  = 1'b0;
    localparam logic PORT_B  = 1'b1;
endpackage

// File: rtl/dpb_mem.sv
module dpb_mem import dpb_pkg::*; #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [BURST_LEN-1:0]                we,
    input  logic [BURST_LEN-1:0][IDX_W-1:0]     idx,
    input  logic [BURST_LEN-1:0][DATA_W-1:0]    wdat,
    output logic [BURST_LEN-1:0][DATA_W-1:0]    rdat
);
    localparam int WORDS = 1 << IDX_W;

    logic [WORDS-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int l = 0; l < BURST_LEN; l++) begin
            if (we[l]) mem_d[idx[l]] = wdat[l];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    for (genvar l = 0; l < BURST_LEN; l++) begin : g_rd
        assign rdat[l] = mem_q[idx[l]];
    end
endmodule

// File: rtl/dpb_cmd_pipe.sv
module dpb_cmd_pipe import dpb_pkg::*; #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int WR_LAT = 3,
    parameter int RD_LAT = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  cmd_addr,
    input  logic                               a_ld_n,
    input  logic                               a_rw_n,
    input  logic                               b_ld_n,
    input  logic                               b_rw_n,
    input  logic [BURST_LEN-1:0][DATA_W-1:0]   lane_rdat,
    output logic                               a_slot,
    output logic [BURST_LEN-1:0]               lane_we,
    output logic [BURST_LEN-1:0]               lane_re,
    output logic [BURST_LEN-1:0]               lane_port,
    output logic [BURST_LEN-1:0][ADDR_W:0]     lane_idx,
    output logic [N_PORT-1:0]                  tap_pre,
    output logic [N_PORT-1:0]                  tap_w0,
    output logic [N_PORT-1:0]                  tap_w1,
    output logic [DATA_W-1:0]                  tap_d0,
    output logic [DATA_W-1:0]                  tap_d1
);
    // stage k holds the command sampled k+1 edges ago
    localparam int WR_STG = 2 * WR_LAT - 1;
    localparam int RD_STG = 2 * RD_LAT - 1;
    localparam int DEPTH  = RD_STG + BURST_LEN;

    typedef struct packed {
        logic                             vld;
        logic                             rd;
        logic                             prt;
        logic [ADDR_W-1:0]                addr;
        logic [BURST_LEN-1:0][DATA_W-1:0] dw;
    } stage_t;

    typedef struct packed {
        logic                    phase;
        stage_t [DEPTH-1:0]      pipe;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        st_d.pipe[0].prt  = st_q.phase;
        st_d.pipe[0].vld  = st_q.phase ? ~b_ld_n : ~a_ld_n;
        st_d.pipe[0].rd   = st_q.phase ?  b_rw_n :  a_rw_n;
        st_d.pipe[0].addr = cmd_addr;
        st_d.pipe[0].dw   = '0;
        for (int k = 1; k < DEPTH; k++) begin
            st_d.pipe[k] = st_q.pipe[k-1];
        end
        // a read fetches each word on the same edge a write would store it
        for (int l = 0; l < BURST_LEN; l++) begin
            if (st_q.pipe[WR_STG+l].vld && st_q.pipe[WR_STG+l].rd)
                st_d.pipe[WR_STG+l+1].dw[l] = lane_rdat[l];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_slot = (st_q.phase == PORT_A);

    for (genvar l = 0; l < BURST_LEN; l++) begin : g_lane
        assign lane_we[l]   = st_q.pipe[WR_STG+l].vld && !st_q.pipe[WR_STG+l].rd;
        assign lane_re[l]   = st_q.pipe[WR_STG+l].vld &&  st_q.pipe[WR_STG+l].rd;
        assign lane_port[l] = st_q.pipe[WR_STG+l].prt;
        assign lane_idx[l]  = {st_q.pipe[WR_STG+l].addr, 1'(l)};
    end

    for (genvar p = 0; p < N_PORT; p++) begin : g_tap
        assign tap_pre[p] = st_q.pipe[RD_STG-1].vld && st_q.pipe[RD_STG-1].rd
                            && (st_q.pipe[RD_STG-1].prt == 1'(p));
        assign tap_w0[p]  = st_q.pipe[RD_STG].vld && st_q.pipe[RD_STG].rd
                            && (st_q.pipe[RD_STG].prt == 1'(p));
        assign tap_w1[p]  = st_q.pipe[RD_STG+1].vld && st_q.pipe[RD_STG+1].rd
                            && (st_q.pipe[RD_STG+1].prt == 1'(p));
    end

    assign tap_d0 = st_q.pipe[RD_STG].dw[0];
    assign tap_d1 = st_q.pipe[RD_STG+1].dw[1];

    // consecutive edges belong to opposite ports (R2)
    assert_lane_ports_differ_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we[0] && lane_we[1]) |-> (lane_port[0] != lane_port[1]));
endmodule

// File: rtl/dpb_port_out.sv
module dpb_port_out #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre,
    input  logic              w0,
    input  logic              w1,
    input  logic [DATA_W-1:0] d0,
    input  logic [DATA_W-1:0] d1,
    output logic              rvalid,
    output logic              oe,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic              valid;
        logic              oe;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d       = '0;
        o_d.valid = pre | w0;
        o_d.oe    = w0 | w1;
        if (w0)      o_d.data = d0;
        else if (w1) o_d.data = d1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rvalid = o_q.valid;
    assign oe     = o_q.oe;
    assign rdata  = o_q.data;

    assert_valid_leads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(o_q.oe) |-> (o_q.valid && $past(o_q.valid)));
    assert_valid_ends_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(o_q.valid) |-> o_q.oe);
    assert_burst_two_words_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(o_q.oe) |=> o_q.oe);
endmodule

// File: rtl/dp_burst_sram.sv
module dp_burst_sram import dpb_pkg::*; #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int WR_LAT = 3,
    parameter int RD_LAT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              a_slot,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              a_ld_n,
    input  logic              a_rw_n,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    output logic              a_oe,
    input  logic              b_ld_n,
    input  logic              b_rw_n,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid,
    output logic              b_oe
);
    localparam int IDX_W = ADDR_W + 1;

    logic [BURST_LEN-1:0]              lane_we, lane_re, lane_port;
    logic [BURST_LEN-1:0][IDX_W-1:0]   lane_idx;
    logic [BURST_LEN-1:0][DATA_W-1:0]  lane_wdat, lane_rdat;
    logic [N_PORT-1:0]                 tap_pre, tap_w0, tap_w1;
    logic [DATA_W-1:0]                 tap_d0, tap_d1;
    logic [N_PORT-1:0]                 valid_w, oe_w;
    logic [N_PORT-1:0][DATA_W-1:0]     rdata_w;

    dpb_cmd_pipe #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_LAT(WR_LAT), .RD_LAT(RD_LAT)
    ) u_pipe (
        .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr),
        .a_ld_n(a_ld_n), .a_rw_n(a_rw_n), .b_ld_n(b_ld_n), .b_rw_n(b_rw_n),
        .lane_rdat(lane_rdat), .a_slot(a_slot),
        .lane_we(lane_we), .lane_re(lane_re), .lane_port(lane_port), .lane_idx(lane_idx),
        .tap_pre(tap_pre), .tap_w0(tap_w0), .tap_w1(tap_w1),
        .tap_d0(tap_d0), .tap_d1(tap_d1)
    );

    for (genvar l = 0; l < BURST_LEN; l++) begin : g_wsel
        assign lane_wdat[l] = (lane_port[l] == PORT_B) ? b_wdata : a_wdata;
    end

    dpb_mem #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(lane_we), .idx(lane_idx),
        .wdat(lane_wdat), .rdat(lane_rdat)
    );

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        dpb_port_out #(.DATA_W(DATA_W)) u_out (
            .clk(clk), .rst_n(rst_n),
            .pre(tap_pre[p]), .w0(tap_w0[p]), .w1(tap_w1[p]),
            .d0(tap_d0), .d1(tap_d1),
            .rvalid(valid_w[p]), .oe(oe_w[p]), .rdata(rdata_w[p])
        );
    end

    assign a_rvalid = valid_w[PORT_A];
    assign a_oe     = oe_w[PORT_A];
    assign a_rdata  = rdata_w[PORT_A];
    assign b_rvalid = valid_w[PORT_B];
    assign b_oe     = oe_w[PORT_B];
    assign b_rdata  = rdata_w[PORT_B];

    // port A data starts on even edges, port B on odd ones (R2)
    assert_ports_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_oe) |-> !$rose(b_oe));
    // a fetch never meets a store to the same word on one edge (R9)
    assert_no_same_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we[0] && lane_re[1]) |-> (lane_idx[0] != lane_idx[1]));
    assert_no_same_word_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we[1] && lane_re[0]) |-> (lane_idx[0] != lane_idx[1]));
endmodule

// File: tb/tb_dp_burst_sram.sv
module tb_dp_burst_sram;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NT = 340;
    localparam int NE = NT + 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          a_slot;
    logic [AW-1:0] cmd_addr;
    logic          a_ld_n, a_rw_n, b_ld_n, b_rw_n;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic          a_rvalid, a_oe, b_rvalid, b_oe;

    dp_burst_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .a_slot(a_slot), .cmd_addr(cmd_addr),
        .a_ld_n(a_ld_n), .a_rw_n(a_rw_n), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .a_rvalid(a_rvalid), .a_oe(a_oe),
        .b_ld_n(b_ld_n), .b_rw_n(b_rw_n), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .b_rvalid(b_rvalid), .b_oe(b_oe)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // schedule: kind 0 = nop, 1 = read, 2 = write
    int        kind [NT];
    int        caddr[NT];
    string     ctag [NT];
    logic [DW-1:0] refm[2**(AW+1)];
    bit        ev[2][NE];
    bit        eo[2][NE];
    logic [DW-1:0] ed[2][NE];
    logic [DW-1:0] wd[2][NE];
    string     etag[2][NE];

    function automatic logic [DW-1:0] dfun(int t, int w);
        return DW'(t * 29 + w * 101 + 5);
    endfunction

    function automatic int unsigned hsh(int t);
        int unsigned h;
        h = t * 32'd2654435761;
        return h ^ (h >> 15);
    endfunction

    task automatic put(int t, int k, int a, string tg);
        kind[t] = k; caddr[t] = a; ctag[t] = tg;
    endtask

    task automatic chk(string req, int p, int n, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s (%s) port %0d edge %0d %s act=%0h exp=%0h",
                     req, etag[p][n], p, n, what, act, exp);
        end
    endtask

    task automatic build();
        for (int t = 0; t < NT; t++) put(t, 0, hsh(t + 7) % 16, "R3");
        for (int n = 0; n < NE; n++) begin
            for (int p = 0; p < 2; p++) begin
                ev[p][n] = 0; eo[p][n] = 0; ed[p][n] = '0;
                wd[p][n] = DW'(hsh(n * 3 + p) >> 4);
                etag[p][n] = "R2/R3";
            end
        end
        for (int i = 0; i < 2**(AW+1); i++) refm[i] = '0;
        // R4/R10: stores then separate fetches
        put(0, 2, 3, "R4"); put(1, 2, 5, "R4"); put(2, 2, 12, "R4"); put(3, 2, 3, "R4");
        put(20, 1, 3, "R4"); put(21, 1, 5, "R4"); put(22, 1, 9, "R10"); put(23, 1, 12, "R10");
        // R8: back-to-back reads on both ports
        put(40, 1, 3, "R8"); put(42, 1, 5, "R8"); put(44, 1, 12, "R8");
        put(41, 1, 12, "R8"); put(43, 1, 3, "R8");
        // R9: reads around pending writes
        put(60, 2, 7, "R9"); put(61, 1, 7, "R9"); put(62, 1, 7, "R9"); put(63, 2, 7, "R9");
        put(64, 1, 7, "R9"); put(65, 2, 9, "R9"); put(66, 1, 7, "R9"); put(67, 2, 7, "R9");
        put(68, 1, 7, "R9"); put(69, 1, 9, "R9");
        // R3/R2: no-ops on addr 3 and 5, then read back
        for (int t = 80; t < 100; t++) put(t, 0, (t % 2) ? 5 : 3, "R3");
        put(100, 1, 3, "R3"); put(101, 1, 5, "R2");
        // mixed traffic
        for (int t = 120; t < 300; t++) put(t, (hsh(t) >> 13) % 3, (hsh(t) >> 7) % 16, "R9");
        // expectations in command order
        for (int t = 0; t < NT; t++) begin
            int p = t % 2;
            int a = caddr[t];
            if (kind[t] == 2) begin
                refm[a*2]     = dfun(t, 0);
                refm[a*2 + 1] = dfun(t, 1);
                wd[p][t+6]    = dfun(t, 0);
                wd[p][t+7]    = dfun(t, 1);
            end else if (kind[t] == 1) begin
                ev[p][t+9] = 1; ev[p][t+10] = 1;
                eo[p][t+10] = 1; eo[p][t+11] = 1;
                ed[p][t+10] = refm[a*2];
                ed[p][t+11] = refm[a*2 + 1];
                for (int n = t + 9; n <= t + 11; n++) etag[p][n] = ctag[t];
            end
        end
    endtask

    task automatic drive(int n);
        int unsigned h = hsh(n + 1000);
        a_wdata = wd[0][n];
        b_wdata = wd[1][n];
        if (n >= NT) begin
            cmd_addr = '0; a_ld_n = 1; a_rw_n = 1; b_ld_n = 1; b_rw_n = 1;
        end else begin
            logic ld, rw;
            cmd_addr = AW'(caddr[n]);
            ld = (kind[n] == 0);
            rw = (kind[n] == 0) ? h[3] : (kind[n] == 1);
            if (n % 2 == 0) begin
                a_ld_n = ld; a_rw_n = rw; b_ld_n = h[5]; b_rw_n = h[9];
            end else begin
                b_ld_n = ld; b_rw_n = rw; a_ld_n = h[5]; a_rw_n = h[9];
            end
        end
    endtask

    task automatic check_edge(int n);
        chk("R6", 0, n, "rvalid", a_rvalid, ev[0][n]);
        chk("R6", 1, n, "rvalid", b_rvalid, ev[1][n]);
        chk("R7", 0, n, "oe", a_oe, eo[0][n]);
        chk("R7", 1, n, "oe", b_oe, eo[1][n]);
        chk("R5", 0, n, "rdata", a_rdata, ed[0][n]);
        chk("R5", 1, n, "rdata", b_rdata, ed[1][n]);
    endtask

    initial begin
        rst_n = 0;
        build();
        drive(NT);
        repeat (4) @(negedge clk);
        // R1: reset state
        total++;
        if ({a_rvalid, b_rvalid, a_oe, b_oe} !== 4'b0 || a_rdata !== '0 || b_rdata !== '0
            || a_slot !== 1'b1) begin
            bad++;
            $display("FAIL R1 reset outputs act=%b_%h_%h_%b exp=0000_00_00_1",
                     {a_rvalid, b_rvalid, a_oe, b_oe}, a_rdata, b_rdata, a_slot);
        end
        rst_n = 1;
        for (int n = 0; n < NT + 14; n++) begin
            if (n > 0) check_edge(n - 1);
            total++;
            if (a_slot !== (n % 2 == 0)) begin
                bad++;
                $display("FAIL R2 a_slot before edge %0d act=%0b exp=%0b", n, a_slot, n % 2 == 0);
            end
            drive(n);
            @(negedge clk);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule